// File: doc/BRIEF.md
# Fault Voting and Reissue Controller

This block sits beside the issue stage of a wide-issue data path in which every operation runs twice, on two functional units (FUs). When the compare logic of an FU reports a first-time disagreement between its result and the reference copy, the controller freezes issue and runs a tie-break execution. It replays the suspect operation's control signals on another FU that implements the same operator and is not yet known to be broken. The compare result of that replay then decides whether the suspect's write-back is blocked.

In normal running, a short queue of decoded control words feeds the data path from its head. If the replay agrees with the reference copy, the suspect FU is judged broken: its write-back is disabled and the (FU, operator) pair is recorded in a fault map that the compare units read. If the replay also disagrees, the suspect's result stands. After the decision, one resume cycle reissues the frozen head word and normal issue continues. Reports from several FUs in the same cycle are handled one after another, and if no FU is left to replay on, a sticky fatal flag is raised.

Top module: `vote_reissue_ctrl`

## Requirements
- R1: After reset, mode is NORMAL (0), stall, fu_sel, op_sel, wr_dis, fault_map and fatal are all zero, and the queue holds no-op words (all zero).
- R2: In every cycle without stall, iss_word equals the queue head. A word presented with dec_valid high in an unstalled cycle appears on iss_word Q_DEPTH (default 2) unstalled cycles later, in order. A cycle with dec_valid low enqueues an all-zero no-op word. Slot f occupies iss_word[f*SLOT_W +: SLOT_W] as {op[OP_W-1:0], ctl[CW_W-1:0]}, and op 0 is a no-op.
- R3: A mis_flag report in NORMAL mode raises stall in that same cycle, freezes the queue and forces iss_word to zero. The next cycle enters VOTE (1).
- R4: The replay FU is the lowest-numbered FU other than the suspect whose bit FU_CAPS[f*NUM_OPS+op] is 1 and whose fault_map bit f*NUM_OPS+op is 0. In the first VOTE cycle, its slot carries the suspect's op and ctl, fu_sel is one-hot on that FU, op_sel is the op, and every other slot is zero.
- R5: MAX_LAT cycles after the replay cycle, vote_mis is sampled. If it is 0, wr_dis[suspect] is high for that one cycle and fault_map bit suspect*NUM_OPS+op is set. If it is 1, wr_dis stays zero and fault_map is unchanged.
- R6: fault_map bits are only ever set, never cleared, outside reset.
- R7: The suspect is the FU whose report is the lowest set bit of mis_flag. The remaining set bits are held and serviced in increasing FU order after each resume, using the words issued in the cycle before the original report.
- R8: The cycle after a decision is RESUME (2). It is unstalled and issues the head, and the following cycle is NORMAL.
- R9: Each vote holds stall high for exactly MAX_LAT+2 consecutive cycles, which is never more than 2*MAX_LAT+1.
- R10: If no FU qualifies under R4, fatal is set and stays set. No replay happens and wr_dis stays zero. Stall lasts one cycle, followed by RESUME.
- R11: mis_flag is ignored in VOTE and RESUME modes and while held reports are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | dec_word carries a decoded instruction |
| dec_word | input | NUM_FU*SLOT_W | Decoded control words, one slot per FU |
| mis_flag | input | NUM_FU | Per-FU first-time mismatch, referring to the previous cycle's iss_word |
| vote_mis | input | 1 | Compare result of the replay, valid MAX_LAT cycles after it |
| iss_word | output | NUM_FU*SLOT_W | Control words driven to the FUs this cycle |
| stall | output | 1 | Fetch and execute are frozen |
| mode | output | 2 | 0 normal, 1 voting, 2 resume |
| fu_sel | output | NUM_FU | One-hot replay FU, in the replay cycle only |
| op_sel | output | OP_W | Operator being replayed, in the replay cycle only |
| wr_dis | output | NUM_FU | Per-FU register-file write suppression |
| fault_map | output | NUM_FU*NUM_OPS | Known broken (FU, operator) pairs |
| fatal | output | 1 | A fault could not be voted on |

## Verification
A stream of words with dec_valid toggling, checked against a scoreboard, shows that the queue keeps order and holds during stalls. Single reports on different FUs, with vote_mis at 0 and at 1, separate the replay-target search, the write-disable timing and the recording step. A two-bit report checks ordering and the snapshot of the issued words, and reports injected during a vote must produce no extra replay. A chain of recorded faults then exhausts the candidates for one operator, including an FU that lacks it, and must end in the fatal path.

// File: rtl/vr_pkg.sv
`timescale 1ns/1ps
package vr_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_VOTE   = 2'd1,
    MODE_RESUME = 2'd2
  } mode_e;

  // index of the least significant set bit, 0 when none is set
  function automatic int unsigned lowest_idx(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // bit position of an (fu, op) pair in the fault map
  function automatic int unsigned map_pos(input int unsigned fu, input int unsigned op,
                                          input int unsigned nops);
    return fu * nops + op;
  endfunction

endpackage

// File: rtl/vr_ctl_queue.sv
`timescale 1ns/1ps
module vr_ctl_queue #(
  parameter int WORD_W  = 40,
  parameter int Q_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic [WORD_W-1:0] head
);
  logic [WORD_W-1:0] st [Q_DEPTH];

  for (genvar g = 0; g < Q_DEPTH; g++) begin : g_stage
    if (g == Q_DEPTH - 1) begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st[g] <= '0;
        else if (adv) st[g] <= in_valid ? in_word : '0;
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st[g] <= '0;
        else if (adv) st[g] <= st[g+1];
      end
    end
  end

  assign head = st[0];
endmodule

// File: rtl/vr_target_pick.sv
`timescale 1ns/1ps
module vr_target_pick #(
  parameter int NUM_FU  = 4,
  parameter int OP_W    = 2,
  parameter int NUM_OPS = 4,
  parameter logic [NUM_FU*NUM_OPS-1:0] CAPS = '1,
  localparam int IDX_W = $clog2(NUM_FU)
) (
  input  logic [OP_W-1:0]           op,
  input  logic [IDX_W-1:0]          suspect,
  input  logic [NUM_FU*NUM_OPS-1:0] fmap,
  output logic                      found,
  output logic [IDX_W-1:0]          target
);
  logic [NUM_FU-1:0] usable;

  for (genvar f = 0; f < NUM_FU; f++) begin : g_cand
    assign usable[f] = CAPS[vr_pkg::map_pos(f, int'(op), NUM_OPS)]
                     && !fmap[vr_pkg::map_pos(f, int'(op), NUM_OPS)]
                     && (suspect != IDX_W'(f));
  end

  always_comb begin
    found  = |usable;
    target = IDX_W'(vr_pkg::lowest_idx(32'(usable)));
  end
endmodule

// File: rtl/vr_fault_store.sv
`timescale 1ns/1ps
module vr_fault_store #(
  parameter int NUM_FU  = 4,
  parameter int OP_W    = 2,
  parameter int NUM_OPS = 4,
  localparam int IDX_W = $clog2(NUM_FU)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rec_en,
  input  logic [IDX_W-1:0]          rec_fu,
  input  logic [OP_W-1:0]           rec_op,
  output logic [NUM_FU*NUM_OPS-1:0] fmap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fmap <= '0;
    else if (rec_en)
      fmap[vr_pkg::map_pos(int'(rec_fu), int'(rec_op), NUM_OPS)] <= 1'b1;
  end
endmodule

// File: rtl/vote_reissue_ctrl.sv
`timescale 1ns/1ps
module vote_reissue_ctrl #(
  parameter int NUM_FU  = 4,
  parameter int OP_W    = 2,
  parameter int CW_W    = 8,
  parameter int MAX_LAT = 2,
  parameter int Q_DEPTH = 2,
  parameter logic [NUM_FU*(1<<OP_W)-1:0] FU_CAPS = 16'hBFFF,
  localparam int NUM_OPS = 1 << OP_W,
  localparam int SLOT_W  = OP_W + CW_W,
  localparam int WORD_W  = NUM_FU * SLOT_W,
  localparam int MAP_W   = NUM_FU * NUM_OPS,
  localparam int IDX_W   = $clog2(NUM_FU),
  localparam int CNT_W   = $clog2(MAX_LAT + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [WORD_W-1:0] dec_word,
  input  logic [NUM_FU-1:0] mis_flag,
  input  logic              vote_mis,
  output logic [WORD_W-1:0] iss_word,
  output logic              stall,
  output logic [1:0]        mode,
  output logic [NUM_FU-1:0] fu_sel,
  output logic [OP_W-1:0]   op_sel,
  output logic [NUM_FU-1:0] wr_dis,
  output logic [MAP_W-1:0]  fault_map,
  output logic              fatal
);
  import vr_pkg::*;

  mode_e             mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] ret_q;
  logic [WORD_W-1:0] snap_q;
  logic [NUM_FU-1:0] pend_q;
  logic [IDX_W-1:0]  susp_q;
  logic [IDX_W-1:0]  tgt_q;
  logic [OP_W-1:0]   sop_q;
  logic [CW_W-1:0]   sctl_q;
  logic              fatal_q;

  // named internal events
  logic [WORD_W-1:0] head_w;
  logic [NUM_FU-1:0] src_mask;
  logic [WORD_W-1:0] src_word;
  logic              hit_ev;
  logic              reissue_ev;
  logic              decide_ev;
  logic              agree_ev;
  logic [IDX_W-1:0]  new_susp;
  logic [SLOT_W-1:0] new_slot;
  logic [OP_W-1:0]   new_op;
  logic [CW_W-1:0]   new_ctl;
  logic              pick_ok;
  logic [IDX_W-1:0]  pick_tgt;

  vr_ctl_queue #(.WORD_W(WORD_W), .Q_DEPTH(Q_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .adv(!stall),
    .in_valid(dec_valid), .in_word(dec_word), .head(head_w)
  );

  always_comb begin
    src_mask = (|pend_q) ? pend_q : mis_flag;
    src_word = (|pend_q) ? snap_q : ret_q;
    hit_ev   = (mode_q == MODE_NORMAL) && (|src_mask);
    new_susp = IDX_W'(lowest_idx(32'(src_mask)));
    new_slot = src_word[int'(new_susp)*SLOT_W +: SLOT_W];
    new_op   = new_slot[SLOT_W-1 -: OP_W];
    new_ctl  = new_slot[CW_W-1:0];
  end

  vr_target_pick #(.NUM_FU(NUM_FU), .OP_W(OP_W), .NUM_OPS(NUM_OPS), .CAPS(FU_CAPS)) u_pick (
    .op(new_op), .suspect(new_susp), .fmap(fault_map),
    .found(pick_ok), .target(pick_tgt)
  );

  assign reissue_ev = (mode_q == MODE_VOTE) && (cnt_q == '0);
  assign decide_ev  = (mode_q == MODE_VOTE) && (cnt_q == CNT_W'(MAX_LAT));
  assign agree_ev   = decide_ev && !vote_mis;

  vr_fault_store #(.NUM_FU(NUM_FU), .OP_W(OP_W), .NUM_OPS(NUM_OPS)) u_store (
    .clk(clk), .rst_n(rst_n), .rec_en(agree_ev),
    .rec_fu(susp_q), .rec_op(sop_q), .fmap(fault_map)
  );

  assign stall = hit_ev || (mode_q == MODE_VOTE);

  always_comb begin
    iss_word = '0;
    if (!stall) iss_word = head_w;
    if (reissue_ev) iss_word[int'(tgt_q)*SLOT_W +: SLOT_W] = {sop_q, sctl_q};
  end

  assign fu_sel = reissue_ev ? (NUM_FU'(1) << tgt_q) : '0;
  assign op_sel = reissue_ev ? sop_q : '0;
  assign wr_dis = agree_ev ? (NUM_FU'(1) << susp_q) : '0;
  assign mode   = mode_q;
  assign fatal  = fatal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORMAL;
      cnt_q   <= '0;
      ret_q   <= '0;
      snap_q  <= '0;
      pend_q  <= '0;
      susp_q  <= '0;
      tgt_q   <= '0;
      sop_q   <= '0;
      sctl_q  <= '0;
      fatal_q <= 1'b0;
    end else begin
      ret_q <= iss_word;
      unique case (mode_q)
        MODE_NORMAL: begin
          if (hit_ev) begin
            pend_q <= src_mask & ~(NUM_FU'(1) << new_susp);
            if (!(|pend_q)) snap_q <= ret_q;
            susp_q <= new_susp;
            sop_q  <= new_op;
            sctl_q <= new_ctl;
            tgt_q  <= pick_tgt;
            cnt_q  <= '0;
            if (pick_ok) begin
              mode_q <= MODE_VOTE;
            end else begin
              fatal_q <= 1'b1;
              mode_q  <= MODE_RESUME;
            end
          end
        end
        MODE_VOTE: begin
          cnt_q <= cnt_q + 1'b1;
          if (decide_ev) mode_q <= MODE_RESUME;
        end
        MODE_RESUME: mode_q <= MODE_NORMAL;
        default:     mode_q <= MODE_NORMAL;
      endcase
    end
  end
endmodule

// File: rtl/vote_reissue_ctrl_chk.sv
`timescale 1ns/1ps
module vote_reissue_ctrl_chk #(
  parameter int NUM_FU  = 4,
  parameter int MAX_LAT = 2,
  parameter int WORD_W  = 40,
  parameter int MAP_W   = 16,
  parameter int IDX_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              stall,
  input logic [NUM_FU-1:0] fu_sel,
  input logic [NUM_FU-1:0] wr_dis,
  input logic [MAP_W-1:0]  fault_map,
  input logic              fatal,
  input logic [IDX_W-1:0]  susp_q,
  input logic [WORD_W-1:0] head_w,
  input logic              hit_ev,
  input logic              decide_ev
);
  int stall_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stall_run <= 0;
    else if (stall) stall_run <= stall_run + 1;
    else            stall_run <= 0;
  end

  assert_vote_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> ($past(mode) == 2'd1 || $past(hit_ev)));

  assert_head_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(head_w));

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fu_sel));

  assert_target_not_suspect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_sel != '0) |-> !fu_sel[susp_q]);

  assert_wrdis_at_decision_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dis != '0) |-> (decide_ev && $countones(wr_dis) == 1));

  assert_map_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_map & $past(fault_map)) == $past(fault_map)));

  assert_decide_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    decide_ev |=> (mode == 2'd2));

  assert_resume_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |=> (mode == 2'd0));

  assert_stall_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_run <= 2 * MAX_LAT + 1);

  assert_fatal_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);
endmodule

bind vote_reissue_ctrl vote_reissue_ctrl_chk #(
  .NUM_FU(NUM_FU), .MAX_LAT(MAX_LAT), .WORD_W(WORD_W), .MAP_W(MAP_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .stall(stall), .fu_sel(fu_sel),
  .wr_dis(wr_dis), .fault_map(fault_map), .fatal(fatal), .susp_q(susp_q),
  .head_w(head_w), .hit_ev(hit_ev), .decide_ev(decide_ev)
);

// File: tb/vote_reissue_ctrl_tb.sv
`timescale 1ns/1ps
module vote_reissue_ctrl_tb;
  localparam int NF = 4, OPW = 2, CWW = 8, LAT = 2, NOPS = 4;
  localparam int SW = OPW + CWW, WW = NF * SW;
  localparam logic [15:0] CAPS = 16'hBFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          dec_valid = 1'b0;
  logic [WW-1:0] dec_word = '0;
  logic [NF-1:0] mis_flag = '0;
  logic          vote_mis = 1'b0;
  logic [WW-1:0] iss_word;
  logic          stall, fatal;
  logic [1:0]    mode, op_sel;
  logic [NF-1:0] fu_sel, wr_dis;
  logic [15:0]   fault_map;

  vote_reissue_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_word(dec_word),
    .mis_flag(mis_flag), .vote_mis(vote_mis), .iss_word(iss_word), .stall(stall),
    .mode(mode), .fu_sel(fu_sel), .op_sel(op_sel), .wr_dis(wr_dis),
    .fault_map(fault_map), .fatal(fatal)
  );

  typedef struct packed {
    logic [1:0] tgt; logic [1:0] op; logic [7:0] ctl; logic [1:0] susp; logic agree;
  } vitem_t;

  logic [WW-1:0] exp_iss[$];
  vitem_t        vq[$];
  int            exp_runs[$];
  logic [15:0]   fm = '0;
  logic          exp_fatal = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic logic [WW-1:0] mk(input logic [7:0] ops, input logic [7:0] cb);
    logic [WW-1:0] w = '0;
    for (int f = 0; f < NF; f++) w[f*SW +: SW] = {ops[f*2 +: 2], 8'(cb + 8'(f))};
    return w;
  endfunction

  // driver: one cycle of stimulus, enqueues expectation when the word is taken
  task automatic cyc(input logic [WW-1:0] w, input logic v, input logic [NF-1:0] m, input logic vm);
    dec_word = w; dec_valid = v; mis_flag = m; vote_mis = vm;
    #1;
    if (!stall) exp_iss.push_back(v ? w : '0);
    @(negedge clk);
  endtask

  // load a word, report faults on it, and predict every vote
  task automatic do_fault(input logic [WW-1:0] w, input logic [NF-1:0] m,
                          input logic [NF-1:0] vm, input logic [NF-1:0] noise);
    int     ncyc [NF];
    logic   vms [NF];
    bit     first;
    cyc(w, 1'b1, '0, 1'b0);
    cyc('0, 1'b0, '0, 1'b0);
    cyc('0, 1'b0, '0, 1'b0);
    for (int s = 0; s < NF; s++) begin
      ncyc[s] = 0; vms[s] = vm[s];
      if (m[s]) begin
        logic [1:0] op;
        bit found;
        logic [1:0] tgt;
        op = w[s*SW + CWW +: 2];
        found = 0; tgt = '0;
        for (int f = NF - 1; f >= 0; f--)
          if (f != s && CAPS[f*NOPS + int'(op)] && !fm[f*NOPS + int'(op)]) begin
            found = 1; tgt = 2'(f);
          end
        if (found) begin
          vq.push_back('{tgt: tgt, op: op, ctl: w[s*SW +: 8], susp: 2'(s), agree: !vm[s]});
          if (!vm[s]) fm[s*NOPS + int'(op)] = 1'b1;
          exp_runs.push_back(LAT + 2);
          ncyc[s] = LAT + 3;
        end else begin
          exp_fatal = 1'b1;
          exp_runs.push_back(1);
          ncyc[s] = 2;
        end
      end
    end
    first = 1;
    for (int s = 0; s < NF; s++) begin
      for (int k = 0; k < ncyc[s]; k++) begin
        logic [NF-1:0] mm;
        mm = (first && k == 0) ? m : ((k == 2 || k == ncyc[s] - 1) ? noise : '0);
        cyc('0, 1'b0, mm, vms[s]);
      end
      if (ncyc[s] != 0) first = 0;
    end
    for (int k = 0; k < 3; k++) cyc('0, 1'b0, '0, 1'b0);
    chk(fault_map == fm, "R5/R6 fault map", 64'(fault_map), 64'(fm));
    chk(fatal == exp_fatal, "R10 fatal flag", 64'(fatal), 64'(exp_fatal));
    chk(mode == 2'd0, "R8 back to normal", 64'(mode), 0);
  endtask

  // monitor
  int run = 0, vcnt = 0;
  bit vact = 0, chk_res = 0;
  vitem_t cur;
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (!stall) begin
        if (exp_iss.size() == 0) chk(0, "R2 unexpected issue", 64'(iss_word), 0);
        else begin
          logic [WW-1:0] e;
          e = exp_iss.pop_front();
          chk(iss_word == e, "R2 issue order", 64'(iss_word), 64'(e));
        end
      end else if (fu_sel == '0) begin
        chk(iss_word == '0, "R3 no-op while stalled", 64'(iss_word), 0);
      end
      if (stall) run++;
      else if (run != 0) begin
        int er;
        er = (exp_runs.size() != 0) ? exp_runs.pop_front() : -1;
        chk(run == er, "R9 stall length", 64'(run), 64'(er));
        run = 0;
      end
      if (fu_sel != '0) begin
        if (vq.size() == 0) chk(0, "R11 unexpected replay", 64'(fu_sel), 0);
        else begin
          logic [WW-1:0] ew;
          cur = vq.pop_front();
          ew = '0;
          ew[int'(cur.tgt)*SW +: SW] = {cur.op, cur.ctl};
          chk(fu_sel == (NF'(1) << cur.tgt), "R4 replay target", 64'(fu_sel), 64'(NF'(1) << cur.tgt));
          chk(op_sel == cur.op, "R4 op_sel", 64'(op_sel), 64'(cur.op));
          chk(iss_word == ew, "R4 replay word", 64'(iss_word), 64'(ew));
          chk(mode == 2'd1, "R3 voting mode", 64'(mode), 1);
          vact = 1; vcnt = 0;
        end
      end else if (vact) vcnt++;
      if (vact || wr_dis != '0) begin
        logic [NF-1:0] ewd;
        ewd = (vact && vcnt == LAT && cur.agree) ? (NF'(1) << cur.susp) : '0;
        chk(wr_dis == ewd, "R5 write disable", 64'(wr_dis), 64'(ewd));
      end
      if (chk_res) begin
        chk(mode == 2'd2 && !stall, "R8 resume cycle", 64'(mode), 2);
        chk_res = 0;
      end
      if (vact && vcnt == LAT) begin vact = 0; chk_res = 1; end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    exp_iss.push_back('0);
    exp_iss.push_back('0);
    repeat (3) @(negedge clk);
    chk(mode == 2'd0 && !stall && fu_sel == '0 && op_sel == '0, "R1 reset mode/stall/sel",
        64'({mode, stall, fu_sel, op_sel}), 0);
    chk(wr_dis == '0 && fault_map == '0 && !fatal, "R1 reset map/wr_dis/fatal",
        64'({wr_dis, fault_map, fatal}), 0);
    rst_n = 1'b1;
    // R2: stream with gaps
    cyc(mk(8'h1B, 8'h10), 1'b1, '0, 1'b0);
    cyc(mk(8'hE4, 8'h20), 1'b1, '0, 1'b0);
    cyc(mk(8'hFF, 8'h30), 1'b0, '0, 1'b0);
    cyc(mk(8'h55, 8'h40), 1'b1, '0, 1'b0);
    cyc('0, 1'b0, '0, 1'b0);
    cyc(mk(8'hAA, 8'h50), 1'b1, '0, 1'b0);
    for (int k = 0; k < 3; k++) cyc('0, 1'b0, '0, 1'b0);
    // R4/R5: FU0 add, replay agrees -> FU1, write-back blocked
    do_fault(mk(8'b11_10_01_01, 8'h60), 4'b0001, 4'b0000, 4'b0000);
    // R4/R5/R11: FU1 add, replay disagrees -> FU2 (FU0 marked), noise ignored
    do_fault(mk(8'b11_10_01_01, 8'h70), 4'b0010, 4'b0010, 4'b0100);
    // R7: two reports at once, FU2 op3 then FU3 op2 from the snapshot
    do_fault(mk(8'b10_11_01_01, 8'h80), 4'b1100, 4'b1000, 4'b0000);
    // R6: FU1 op2 recorded
    do_fault(mk(8'b01_01_10_01, 8'h90), 4'b0010, 4'b0000, 4'b0000);
    // R4: FU0 op2, FU1 marked so FU2 is chosen
    do_fault(mk(8'b01_01_01_10, 8'hA0), 4'b0001, 4'b0000, 4'b0000);
    // R10: FU2 op2, FU0/FU1 marked and FU3 lacks op2 -> fatal
    do_fault(mk(8'b01_10_01_01, 8'hB0), 4'b0100, 4'b0000, 4'b0000);
    // R2 after recovery
    cyc(mk(8'h39, 8'hC0), 1'b1, '0, 1'b0);
    for (int k = 0; k < 4; k++) cyc('0, 1'b0, '0, 1'b0);
    chk(vq.size() == 0, "R4 all replays seen", 64'(vq.size()), 0);
    chk(exp_runs.size() == 0, "R9 all stalls seen", 64'(exp_runs.size()), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule